// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives configuration words over a three-wire serial port (serial clock, serial data, frame enable) and holds them in five parallel registers that drive the synthesizer dividers, the reference selection, the controller clock output, the power state, the audio mutes and volume, and the receiver trim settings. All three serial inputs are asynchronous to the system clock. They are resynchronised, and serial clock edges are detected in the system clock domain.

A frame is the interval between two transitions of the enable line. Data bits are shifted in most significant bit first, one on each serial clock rising edge. When the enable line changes level, the frame that has just ended is committed if it held exactly 16 bits. In a frame sent with enable low, the two top bits of the word select one of four main registers. In a frame sent with enable high, the word goes to the auxiliary register, but only if its top bit is set. All outputs reset to fixed defaults.

Top module: `sreg_loader`

## Requirements
- R1: After reset, and again after any later reset, the outputs are: power mode 11 (inactive), all control flags 0, volume 0, controller clock divider select 11, RX divider 7215, TX divider 9966, reference divider 2048, reference select 00, capacitor select 0, carrier threshold 1010, low-battery level 000, test bits 00.
- R2: A 16-bit frame sent with enable low whose bits 15:14 are 00 loads the control register from bits 13:0. Bit positions are: 13:12 power mode (00 rx, 01 active, 10 standby, 11 inactive), 11 low-battery detector off, 10 compressor mute, 9 expander mute, 8 speaker mute, 7:4 volume, 3 lock/carrier output select, 2 controller clock mute, 1:0 controller clock divider select.
- R3: A 16-bit frame sent with enable low whose bits 15:14 are 01 loads the RX divider from bits 13:0.
- R4: A 16-bit frame sent with enable low whose bits 15:14 are 10 loads the reference divider from bits 11:0 and the reference select from bits 13:12.
- R5: A 16-bit frame sent with enable low whose bits 15:14 are 11 loads the TX divider from bits 13:0.
- R6: A 16-bit frame sent with enable high whose bit 15 is 1 loads the auxiliary register. Its fields are: bits 14:9 capacitor select, 8:5 carrier threshold, 4:2 low-battery level, 1:0 test bits.
- R7: A 16-bit frame sent with enable high whose bit 15 is 0 changes no output.
- R8: A frame of any length other than 16 serial clocks (0, 15 or 17 clocks) changes no output, at either enable level.
- R9: A committed word changes only its destination register. All other outputs keep their values.
- R10: Outputs change only after the enable transition that ends a frame, never while bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| sen_i | input | 1 | Frame enable; its level picks the bank |
| pwr_mode_o | output | 2 | Power mode |
| lbd_off_o | output | 1 | Low-battery detector off |
| mute_comp_o | output | 1 | Compressor mute |
| mute_exp_o | output | 1 | Expander mute |
| mute_spk_o | output | 1 | Speaker mute |
| volume_o | output | 4 | Speaker volume code |
| lock_sel_o | output | 1 | Lock/carrier output select (0 carrier) |
| mclk_mute_o | output | 1 | Controller clock mute |
| mclk_div_o | output | 2 | Controller clock divider select |
| rx_div_o | output | 14 | RX divider |
| tx_div_o | output | 14 | TX divider |
| ref_div_o | output | 12 | Reference divider |
| ref_sel_o | output | 2 | Reference select |
| cap_sel_o | output | 6 | Oscillator capacitor select |
| cd_thresh_o | output | 4 | Carrier threshold code |
| lbd_level_o | output | 3 | Low-battery level code |
| test_o | output | 2 | Test bits |

## Verification
Each serial input passes through two synchroniser stages and is then compared with a delayed copy. The commit is registered, and the destination register loads one edge later, so an output is due on the fourth rising system clock edge after an enable transition. A shifted data bit is due at the same depth after a serial clock rise. The bench holds every serial level for at least three system clocks and waits eight clocks after the frame-ending transition before it samples, always on the falling edge. For R10 it also samples before that transition, while the complete word already sits in the shift register.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W = 16;
  localparam int DIV_W  = 14;
  localparam int REF_W  = 12;
  localparam int CAP_W  = 6;
  localparam int CD_W   = 4;
  localparam int LBD_W  = 3;
  localparam int TST_W  = 2;
  localparam int VOL_W  = 4;

  typedef enum logic [1:0] {
    PWR_RX       = 2'b00,
    PWR_ACTIVE   = 2'b01,
    PWR_STANDBY  = 2'b10,
    PWR_INACTIVE = 2'b11
  } pwr_mode_e;

  // layout matches word bits 13:0
  typedef struct packed {
    pwr_mode_e        pwr;
    logic             lbd_off;
    logic             mute_comp;
    logic             mute_exp;
    logic             mute_spk;
    logic [VOL_W-1:0] vol;
    logic             lock_sel;
    logic             mclk_mute;
    logic [1:0]       mclk_div;
  } ctrl_t;

  // layout matches word bits 14:0
  typedef struct packed {
    logic [CAP_W-1:0] cap;
    logic [CD_W-1:0]  cd;
    logic [LBD_W-1:0] lbd;
    logic [TST_W-1:0] tst;
  } aux_t;

  typedef enum logic [1:0] {
    DST_CTRL = 2'b00,
    DST_RX   = 2'b01,
    DST_REF  = 2'b10,
    DST_TX   = 2'b11
  } dst_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sreg_framer.sv
module sreg_framer
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  input  logic              sen_s_i,
  output logic              commit_o,
  output logic              bank_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sen_q, sclk_q;
  logic              en_edge, clk_rise;

  assign en_edge  = sen_s_i != sen_q;
  assign clk_rise = sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      sen_q    <= 1'b0;
      sclk_q   <= 1'b0;
      commit_o <= 1'b0;
      bank_o   <= 1'b0;
      word_o   <= '0;
    end else begin
      sen_q    <= sen_s_i;
      sclk_q   <= sclk_s_i;
      commit_o <= 1'b0;
      if (en_edge) begin
        // frame ends: only an exact-length word is handed on
        commit_o <= (cnt_q == CNT_W'(WORD_W));
        bank_o   <= sen_q;
        word_o   <= shreg_q;
        cnt_q    <= '0;
      end else if (clk_rise) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdata_s_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter logic [DIV_W-1:0] RX_DEF  = DIV_W'(7215),
  parameter logic [DIV_W-1:0] TX_DEF  = DIV_W'(9966),
  parameter logic [REF_W-1:0] REF_DEF = REF_W'(2048),
  parameter logic [CD_W-1:0]  CD_DEF  = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              bank_i,
  input  logic [WORD_W-1:0] word_i,
  output ctrl_t             ctrl_o,
  output aux_t              aux_o,
  output logic [DIV_W-1:0]  rx_div_o,
  output logic [DIV_W-1:0]  tx_div_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [1:0]        ref_sel_o
);
  localparam ctrl_t CTRL_DEF = '{pwr: PWR_INACTIVE, mclk_div: 2'b11, default: '0};
  localparam aux_t  AUX_DEF  = '{cd: CD_DEF, default: '0};

  dst_e dst;
  logic main_wr, aux_wr;

  assign dst     = dst_e'(word_i[WORD_W-1 -: 2]);
  assign main_wr = commit_i & ~bank_i;
  assign aux_wr  = commit_i & bank_i & word_i[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= CTRL_DEF;
      aux_o     <= AUX_DEF;
      rx_div_o  <= RX_DEF;
      tx_div_o  <= TX_DEF;
      ref_div_o <= REF_DEF;
      ref_sel_o <= 2'b00;
    end else begin
      if (main_wr) begin
        unique case (dst)
          DST_CTRL: ctrl_o   <= ctrl_t'(word_i[DIV_W-1:0]);
          DST_RX:   rx_div_o <= word_i[DIV_W-1:0];
          DST_REF: begin
            ref_div_o <= word_i[REF_W-1:0];
            ref_sel_o <= word_i[DIV_W-1 -: 2];
          end
          DST_TX:   tx_div_o <= word_i[DIV_W-1:0];
          default: ;
        endcase
      end
      if (aux_wr) aux_o <= aux_t'(word_i[WORD_W-2:0]);
    end
  end
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             sen_i,
  output logic [1:0]       pwr_mode_o,
  output logic             lbd_off_o,
  output logic             mute_comp_o,
  output logic             mute_exp_o,
  output logic             mute_spk_o,
  output logic [VOL_W-1:0] volume_o,
  output logic             lock_sel_o,
  output logic             mclk_mute_o,
  output logic [1:0]       mclk_div_o,
  output logic [DIV_W-1:0] rx_div_o,
  output logic [DIV_W-1:0] tx_div_o,
  output logic [REF_W-1:0] ref_div_o,
  output logic [1:0]       ref_sel_o,
  output logic [CAP_W-1:0] cap_sel_o,
  output logic [CD_W-1:0]  cd_thresh_o,
  output logic [LBD_W-1:0] lbd_level_o,
  output logic [TST_W-1:0] test_o
);
  logic [2:0]        sync_w;
  logic              commit_w, bank_w;
  logic [WORD_W-1:0] word_w;
  ctrl_t             ctrl_w;
  aux_t              aux_w;

  sreg_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk_i, .rst_ni,
    .async_i({sclk_i, sdata_i, sen_i}),
    .sync_o (sync_w)
  );

  sreg_framer u_framer (
    .clk_i, .rst_ni,
    .sclk_s_i (sync_w[2]),
    .sdata_s_i(sync_w[1]),
    .sen_s_i  (sync_w[0]),
    .commit_o (commit_w),
    .bank_o   (bank_w),
    .word_o   (word_w)
  );

  sreg_bank u_bank (
    .clk_i, .rst_ni,
    .commit_i (commit_w),
    .bank_i   (bank_w),
    .word_i   (word_w),
    .ctrl_o   (ctrl_w),
    .aux_o    (aux_w),
    .rx_div_o (rx_div_o),
    .tx_div_o (tx_div_o),
    .ref_div_o(ref_div_o),
    .ref_sel_o(ref_sel_o)
  );

  assign pwr_mode_o  = ctrl_w.pwr;
  assign lbd_off_o   = ctrl_w.lbd_off;
  assign mute_comp_o = ctrl_w.mute_comp;
  assign mute_exp_o  = ctrl_w.mute_exp;
  assign mute_spk_o  = ctrl_w.mute_spk;
  assign volume_o    = ctrl_w.vol;
  assign lock_sel_o  = ctrl_w.lock_sel;
  assign mclk_mute_o = ctrl_w.mclk_mute;
  assign mclk_div_o  = ctrl_w.mclk_div;
  assign cap_sel_o   = aux_w.cap;
  assign cd_thresh_o = aux_w.cd;
  assign lbd_level_o = aux_w.lbd;
  assign test_o      = aux_w.tst;
endmodule

// File: rtl/sreg_loader_chk.sv
module sreg_loader_chk
  import sreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit,
  input logic              bank,
  input logic [WORD_W-1:0] word,
  input logic [DIV_W-1:0]  ctrl_bus,
  input logic [DIV_W-1:0]  rx_div,
  input logic [DIV_W-1:0]  tx_div,
  input logic [DIV_W-1:0]  ref_bus,
  input logic [WORD_W-2:0] aux_bus
);
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable({ctrl_bus, rx_div, tx_div, ref_bus, aux_bus}));

  // R7
  aux_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && bank && !word[WORD_W-1]) |=> $stable(aux_bus));

  // R6
  aux_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && bank && word[WORD_W-1]) |=> aux_bus == $past(word[WORD_W-2:0]));

  // R3
  rx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !bank && word[15:14] == 2'b01) |=> rx_div == $past(word[DIV_W-1:0]));

  // R5
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !bank && word[15:14] == 2'b11) |=> tx_div == $past(word[DIV_W-1:0]));

  // R9
  rx_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && (bank || word[15:14] != 2'b01)) |=> $stable(rx_div));

  // R9
  ctrl_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && (bank || word[15:14] != 2'b00)) |=> $stable(ctrl_bus));
endmodule

bind sreg_loader sreg_loader_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .commit  (commit_w),
  .bank    (bank_w),
  .word    (word_w),
  .ctrl_bus(ctrl_w),
  .rx_div  (rx_div_o),
  .tx_div  (tx_div_o),
  .ref_bus ({ref_sel_o, ref_div_o}),
  .aux_bus (aux_w)
);

// File: tb/sim_sreg_loader.sv
module sim_sreg_loader;
  typedef struct packed {
    logic        en_hi;
    logic [4:0]  nbits;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd16, 32'h0000_1D9A, 4'd2},  // R2 control
    '{1'b0, 5'd16, 32'h0000_6A5C, 4'd3},  // R3 rx
    '{1'b0, 5'd16, 32'h0000_A123, 4'd4},  // R4 reference
    '{1'b0, 5'd16, 32'h0000_FFFF, 4'd5},  // R5 tx max
    '{1'b1, 5'd16, 32'h0000_DA79, 4'd6},  // R6 aux
    '{1'b1, 5'd16, 32'h0000_7FFF, 4'd7},  // R7 aux, top bit clear
    '{1'b0, 5'd15, 32'h0000_1234, 4'd8},  // R8 short
    '{1'b0, 5'd17, 32'h0001_4321, 4'd8},  // R8 long
    '{1'b1, 5'd17, 32'h0001_FFFF, 4'd8},  // R8 long, high bank
    '{1'b0, 5'd16, 32'h0000_2F05, 4'd2},  // R2 other fields
    '{1'b0, 5'd16, 32'h0000_4010, 4'd9},  // R9 rx only
    '{1'b1, 5'd16, 32'h0000_8000, 4'd6},  // R6 aux clear
    '{1'b0, 5'd0,  32'h0000_0000, 4'd8}   // R8 empty frame
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b1;
  logic [1:0] pwr_mode, mclk_div, ref_sel, test;
  logic lbd_off, mute_comp, mute_exp, mute_spk, lock_sel, mclk_mute;
  logic [3:0] volume, cd_thresh;
  logic [13:0] rx_div, tx_div;
  logic [11:0] ref_div;
  logic [5:0] cap_sel;
  logic [2:0] lbd_level;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [13:0] m_ctrl, m_rx, m_tx, m_ref;
  logic [14:0] m_aux;

  always #2 clk = ~clk;

  sreg_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .pwr_mode_o(pwr_mode), .lbd_off_o(lbd_off), .mute_comp_o(mute_comp),
    .mute_exp_o(mute_exp), .mute_spk_o(mute_spk), .volume_o(volume),
    .lock_sel_o(lock_sel), .mclk_mute_o(mclk_mute), .mclk_div_o(mclk_div),
    .rx_div_o(rx_div), .tx_div_o(tx_div), .ref_div_o(ref_div), .ref_sel_o(ref_sel),
    .cap_sel_o(cap_sel), .cd_thresh_o(cd_thresh), .lbd_level_o(lbd_level),
    .test_o(test)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 14'h3003; m_rx = 14'd7215; m_tx = 14'd9966;
    m_ref = 14'h0800;  m_aux = 15'h0140;
  endtask

  task automatic check_all(input string req);
    chk(req, "ctrl", {2'b0, pwr_mode, lbd_off, mute_comp, mute_exp, mute_spk, volume,
                      lock_sel, mclk_mute, mclk_div}, {2'b0, m_ctrl});
    chk(req, "rx", {2'b0, rx_div}, {2'b0, m_rx});
    chk(req, "tx", {2'b0, tx_div}, {2'b0, m_tx});
    chk(req, "ref_div", {4'b0, ref_div}, {4'b0, m_ref[11:0]});
    chk(req, "ref_sel", {14'b0, ref_sel}, {14'b0, m_ref[13:12]});
    chk(req, "aux", {1'b0, cap_sel, cd_thresh, lbd_level, test}, {1'b0, m_aux});
  endtask

  task automatic clock_bit(input logic b);
    sdata = b; wait_n(3);
    sclk = 1'b1; wait_n(3);
    sclk = 1'b0; wait_n(3);
  endtask

  // open a frame at level lvl, shift n bits, close it
  task automatic send(input logic lvl, input int n, input logic [31:0] d);
    sen = ~lvl; wait_n(8);
    sen = lvl;  wait_n(8);
    for (int i = n - 1; i >= 0; i--) clock_bit(d[i]);
    sen = ~lvl; wait_n(8);
  endtask

  task automatic model_apply(input vec_t v);
    if (v.nbits == 5'd16) begin
      if (!v.en_hi) begin
        case (v.data[15:14])
          2'b00: m_ctrl = v.data[13:0];
          2'b01: m_rx   = v.data[13:0];
          2'b10: m_ref  = v.data[13:0];
          default: m_tx = v.data[13:0];
        endcase
      end else if (v.data[15]) begin
        m_aux = v.data[14:0];
      end
    end
  endtask

  initial begin
    model_reset();
    wait_n(4);
    check_all("R1");  // reset values
    rst_ni = 1'b1;
    wait_n(10);
    check_all("R1");

    for (int k = 0; k < NV; k++) begin
      send(VEC[k].en_hi, int'(VEC[k].nbits), VEC[k].data);
      model_apply(VEC[k]);
      check_all($sformatf("R%0d", VEC[k].req));
    end

    // R10: full word shifted, frame not closed yet
    sen = 1'b1; wait_n(8);
    sen = 1'b0; wait_n(8);
    for (int i = 15; i >= 0; i--) clock_bit(1'(16'h4ABC >> i));
    wait_n(10);
    chk("R10", "rx before close", {2'b0, rx_div}, {2'b0, m_rx});
    sen = 1'b1; wait_n(8);
    m_rx = 14'h0ABC;
    chk("R10", "rx after close", {2'b0, rx_div}, {2'b0, m_rx});
    check_all("R9");

    // R1: reset after activity
    rst_ni = 1'b0; wait_n(3);
    model_reset();
    check_all("R1");
    rst_ni = 1'b1; wait_n(10);
    check_all("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule